// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the 32-bit architectural register file of a processor core that runs in several privilege modes. It holds sixteen general registers and a saved copy of the status word. It also holds the current status word. The low five bits of that word select the operating mode, and the mode decides which physical copy of certain registers a port reaches. A core reads two registers and writes one register per cycle through index-addressed ports. It changes mode by writing a new status word on a separate port.

Each of the seven modes has its own stack register (index 13), its own link register (index 14) and its own saved status. Registers 8 to 12 have two copies. The fast-interrupt mode uses one copy and every other mode uses the other. Registers 0 to 7 and 15 are shared by all modes. A status word that carries an unknown mode code is refused. The block keeps its state and raises an error flag for one cycle.

Top module: `banked_regfile`

## Requirements
- R1: While reset is asserted, and until the first status write after it, status_o reads 0x000000D3 (supervisor mode, both interrupt mask bits 7 and 6 set), mode_idx_o reads 3, mode_err_o reads 0, and every register and every saved status reads zero.
- R2: mode_idx_o gives the mode in effect: code 0x10 gives 0 (user), 0x11 gives 1 (fast interrupt), 0x12 gives 2 (interrupt), 0x13 gives 3 (supervisor), 0x17 gives 4 (abort), 0x1B gives 5 (undefined) and 0x1F gives 6 (system). The code is bits 4:0 of the status word.
- R3: A status write whose bits 4:0 hold one of the seven valid codes replaces status_o with sr_data_i at the next clock edge, and mode_idx_o follows in the same cycle.
- R4: A status write with any other code leaves status_o, mode_idx_o and all register contents unchanged. mode_err_o is high in exactly the cycle after that write and low otherwise.
- R5: Registers 0 to 7 and 15 are one set shared by every mode.
- R6: Registers 13 and 14 and the saved status each have a separate copy per mode. Leaving a mode and returning to it gives back the values it held.
- R7: Registers 8 to 12 have one copy for the fast-interrupt mode and one copy shared by all six other modes. Entering or leaving the fast-interrupt mode swaps these copies.
- R8: A status write that keeps the current mode code replaces only the status word. No register value seen through the ports changes.
- R9: A register write or saved-status write issued in the same cycle as a status write lands in the bank of the mode in effect before that edge.
- R10: Reads are combinational on the registered state. A value written at an edge is visible from the cycle after it, with no bypass in the cycle of the write.
- R11: saved_sr_o shows the saved status of the current mode. A saved-status write sets it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Register write index |
| wr_data_i | input | 32 | Register write data |
| spsr_wr_en_i | input | 1 | Saved-status write enable |
| spsr_data_i | input | 32 | Saved-status write data |
| sr_wr_en_i | input | 1 | Status word write enable |
| sr_data_i | input | 32 | New status word |
| status_o | output | 32 | Current status word |
| saved_sr_o | output | 32 | Saved status of the current mode |
| mode_idx_o | output | 3 | Current mode index |
| mode_err_o | output | 1 | One-cycle pulse after a refused status write |

## Verification
A write, a status change or a refused mode code takes effect at the first clock edge after it is presented. status_o, mode_idx_o, saved_sr_o and mode_err_o are therefore compared one edge after the stimulus. The read ports are combinational on the registered state. The bench compares them in the same cycle their indices are driven, before the edge, against a model that has not yet absorbed that cycle's writes. This timing also confirms that a write has no same-cycle bypass. The bench drives all inputs at the falling edge and updates its model at the rising edge. It compares every output one time unit after the falling edge.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int unsigned NUM_MODES = 7;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned SP_IDX    = 13;
  localparam int unsigned LR_IDX    = 14;
  localparam int unsigned FIQ_LO    = 8;
  localparam int unsigned FIQ_HI    = 12;
  localparam int unsigned NUM_FIQ   = FIQ_HI - FIQ_LO + 1;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 3'd0,
    M_FIQ = 3'd1,
    M_IRQ = 3'd2,
    M_SVC = 3'd3,
    M_ABT = 3'd4,
    M_UND = 3'd5,
    M_SYS = 3'd6
  } mode_e;

  localparam logic [4:0] CODE_USR = 5'h10;
  localparam logic [4:0] CODE_FIQ = 5'h11;
  localparam logic [4:0] CODE_IRQ = 5'h12;
  localparam logic [4:0] CODE_SVC = 5'h13;
  localparam logic [4:0] CODE_ABT = 5'h17;
  localparam logic [4:0] CODE_UND = 5'h1B;
  localparam logic [4:0] CODE_SYS = 5'h1F;

  // supervisor, both interrupt masks set
  localparam logic [31:0] RESET_SR = 32'h0000_00D3;
endpackage

// File: rtl/mode_decoder.sv
module mode_decoder
  import bank_pkg::*;
(
  input  logic [4:0] code_i,
  output mode_e      mode_o,
  output logic       valid_o
);
  always_comb begin
    valid_o = 1'b1;
    mode_o  = M_USR;
    case (code_i)
      CODE_USR: mode_o = M_USR;
      CODE_FIQ: mode_o = M_FIQ;
      CODE_IRQ: mode_o = M_IRQ;
      CODE_SVC: mode_o = M_SVC;
      CODE_ABT: mode_o = M_ABT;
      CODE_UND: mode_o = M_UND;
      CODE_SYS: mode_o = M_SYS;
      default:  valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/shared_bank.sv
// Registers common to all modes plus the two copies of the fast-interrupt range.
module shared_bank
  import bank_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_fiq_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o
);
  logic [DATA_W-1:0] common_q [NUM_REGS];
  logic [DATA_W-1:0] fiq_q    [NUM_FIQ];

  function automatic logic in_fiq_range(input logic [IDX_W-1:0] idx);
    return (idx >= IDX_W'(FIQ_LO)) && (idx <= IDX_W'(FIQ_HI));
  endfunction

  logic wr_fiq;
  assign wr_fiq = in_fiq_i && in_fiq_range(wr_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NUM_REGS; r++) common_q[r] <= '0;
      for (int k = 0; k < NUM_FIQ; k++)  fiq_q[k]    <= '0;
    end else if (wr_en_i) begin
      if (wr_fiq) begin
        for (int k = 0; k < NUM_FIQ; k++)
          if (wr_idx_i == IDX_W'(FIQ_LO + k)) fiq_q[k] <= wr_data_i;
      end else begin
        common_q[wr_idx_i] <= wr_data_i;
      end
    end
  end

  logic [IDX_W-1:0] rd_idx [2];
  logic [DATA_W-1:0] rd_data [2];
  assign rd_idx[0] = rd_a_idx_i;
  assign rd_idx[1] = rd_b_idx_i;

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      rd_data[p] = common_q[rd_idx[p]];
      if (in_fiq_i) begin
        for (int k = 0; k < NUM_FIQ; k++)
          if (rd_idx[p] == IDX_W'(FIQ_LO + k)) rd_data[p] = fiq_q[k];
      end
    end
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/mode_bank.sv
// Per-mode stack, link and saved-status copies, selected by the mode index.
module mode_bank
  import bank_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              sp_we_i,
  input  logic              lr_we_i,
  input  logic              spsr_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] spsr_data_i,
  output logic [DATA_W-1:0] sp_o,
  output logic [DATA_W-1:0] lr_o,
  output logic [DATA_W-1:0] spsr_o
);
  logic [DATA_W-1:0] sp_q   [NUM_MODES];
  logic [DATA_W-1:0] lr_q   [NUM_MODES];
  logic [DATA_W-1:0] spsr_q [NUM_MODES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int m = 0; m < NUM_MODES; m++) begin
        sp_q[m]   <= '0;
        lr_q[m]   <= '0;
        spsr_q[m] <= '0;
      end
    end else begin
      for (int m = 0; m < NUM_MODES; m++) begin
        if (mode_i == mode_e'(m)) begin
          if (sp_we_i)   sp_q[m]   <= wr_data_i;
          if (lr_we_i)   lr_q[m]   <= wr_data_i;
          if (spsr_we_i) spsr_q[m] <= spsr_data_i;
        end
      end
    end
  end

  always_comb begin
    sp_o   = '0;
    lr_o   = '0;
    spsr_o = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (mode_i == mode_e'(m)) begin
        sp_o   = sp_q[m];
        lr_o   = lr_q[m];
        spsr_o = spsr_q[m];
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bank_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              spsr_wr_en_i,
  input  logic [DATA_W-1:0] spsr_data_i,
  input  logic              sr_wr_en_i,
  input  logic [DATA_W-1:0] sr_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] saved_sr_o,
  output logic [MODE_W-1:0] mode_idx_o,
  output logic              mode_err_o
);
  logic [DATA_W-1:0] status_q;
  mode_e             mode_q;
  logic              err_q;
  mode_e             new_mode;
  logic              new_valid;

  mode_decoder u_dec (
    .code_i  (sr_data_i[4:0]),
    .mode_o  (new_mode),
    .valid_o (new_valid)
  );

  // decoded mode is registered alongside the status word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= DATA_W'(RESET_SR);
      mode_q   <= M_SVC;
      err_q    <= 1'b0;
    end else begin
      err_q <= sr_wr_en_i && !new_valid;
      if (sr_wr_en_i && new_valid) begin
        status_q <= sr_data_i;
        mode_q   <= new_mode;
      end
    end
  end

  logic wr_sp, wr_lr, wr_shared;
  assign wr_sp     = wr_en_i && (wr_idx_i == IDX_W'(SP_IDX));
  assign wr_lr     = wr_en_i && (wr_idx_i == IDX_W'(LR_IDX));
  assign wr_shared = wr_en_i && !wr_sp && !wr_lr;

  logic [DATA_W-1:0] sh_a, sh_b, sp_cur, lr_cur, spsr_cur;

  shared_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_shared (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_fiq_i    (mode_q == M_FIQ),
    .wr_en_i     (wr_shared),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .rd_a_idx_i  (rd_a_idx_i),
    .rd_b_idx_i  (rd_b_idx_i),
    .rd_a_data_o (sh_a),
    .rd_b_data_o (sh_b)
  );

  mode_bank #(.DATA_W(DATA_W)) u_modes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .sp_we_i     (wr_sp),
    .lr_we_i     (wr_lr),
    .spsr_we_i   (spsr_wr_en_i),
    .wr_data_i   (wr_data_i),
    .spsr_data_i (spsr_data_i),
    .sp_o        (sp_cur),
    .lr_o        (lr_cur),
    .spsr_o      (spsr_cur)
  );

  function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx,
                                             input logic [DATA_W-1:0] shared);
    if (idx == IDX_W'(SP_IDX))      return sp_cur;
    else if (idx == IDX_W'(LR_IDX)) return lr_cur;
    else                            return shared;
  endfunction

  assign rd_a_data_o = pick(rd_a_idx_i, sh_a);
  assign rd_b_data_o = pick(rd_b_idx_i, sh_b);
  assign status_o    = status_q;
  assign saved_sr_o  = spsr_cur;
  assign mode_idx_o  = mode_q;
  assign mode_err_o  = err_q;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic              spsr_wr_en_i,
  input logic [DATA_W-1:0] spsr_data_i,
  input logic              sr_wr_en_i,
  input logic [DATA_W-1:0] sr_data_i,
  input logic [DATA_W-1:0] status_o,
  input logic [DATA_W-1:0] saved_sr_o,
  input logic [2:0]        mode_idx_o,
  input logic              mode_err_o
);
  function automatic logic code_ok(input logic [4:0] c);
    return c inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  // R2
  a_r2_mode_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_idx_o < 3'd7);

  a_r3_status_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_en_i && code_ok(sr_data_i[4:0]) |=> status_o == $past(sr_data_i));

  a_r4_bad_code_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_en_i && !code_ok(sr_data_i[4:0]) |=> $stable(status_o) && $stable(mode_idx_o) && mode_err_o);

  a_r4_err_only_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i |=> !mode_err_o);

  a_r3_mode_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_wr_en_i |=> $stable(mode_idx_o) && $stable(status_o));

  a_r11_saved_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spsr_wr_en_i && !sr_wr_en_i |=> saved_sr_o == $past(spsr_data_i));

  a_r8_same_mode_keeps_saved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_wr_en_i && !spsr_wr_en_i && sr_data_i[4:0] == status_o[4:0] |=> $stable(saved_sr_o));

  // wr_en_i and wr_idx_i are part of the port set but need no property here
  logic unused_ok;
  assign unused_ok = wr_en_i ^ (^wr_idx_i);
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, spsr_data = '0, sr_data = '0;
  logic        wr_en = 1'b0, spsr_wr_en = 1'b0, sr_wr_en = 1'b0;
  logic [31:0] status, saved_sr;
  logic [2:0]  mode_idx;
  logic        mode_err;

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .spsr_wr_en_i(spsr_wr_en), .spsr_data_i(spsr_data),
    .sr_wr_en_i(sr_wr_en), .sr_data_i(sr_data),
    .status_o(status), .saved_sr_o(saved_sr),
    .mode_idx_o(mode_idx), .mode_err_o(mode_err)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model: live registers plus swap-on-change banks
  logic [31:0] m_cur [16];
  logic [31:0] m_spsr;
  logic [31:0] m_bsp [7], m_blr [7], m_bspsr [7];
  logic [31:0] m_usr_hi [5], m_fiq_hi [5];
  logic [31:0] m_status;
  logic        m_err;

  function automatic int code2mode(input logic [4:0] c);
    case (c)
      5'h10: return 0;
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      5'h1F: return 6;
      default: return -1;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_cur[i] = '0;
    for (int i = 0; i < 7; i++) begin m_bsp[i] = '0; m_blr[i] = '0; m_bspsr[i] = '0; end
    for (int i = 0; i < 5; i++) begin m_usr_hi[i] = '0; m_fiq_hi[i] = '0; end
    m_spsr = '0; m_status = 32'h0000_00D3; m_err = 1'b0;
  endtask

  task automatic model_step();
    int om, nm;
    if (wr_en) m_cur[wr_idx] = wr_data;
    if (spsr_wr_en) m_spsr = spsr_data;
    m_err = 1'b0;
    if (sr_wr_en) begin
      nm = code2mode(sr_data[4:0]);
      om = code2mode(m_status[4:0]);
      if (nm < 0) m_err = 1'b1;
      else begin
        if (nm != om) begin
          m_bsp[om] = m_cur[13]; m_blr[om] = m_cur[14]; m_bspsr[om] = m_spsr;
          if (om == 1)
            for (int i = 0; i < 5; i++) begin m_fiq_hi[i] = m_cur[8+i]; m_cur[8+i] = m_usr_hi[i]; end
          m_cur[13] = m_bsp[nm]; m_cur[14] = m_blr[nm]; m_spsr = m_bspsr[nm];
          if (nm == 1)
            for (int i = 0; i < 5; i++) begin m_usr_hi[i] = m_cur[8+i]; m_cur[8+i] = m_fiq_hi[i]; end
        end
        m_status = sr_data;
      end
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic string reg_tag(input int i);
    if (i == 13 || i == 14) return "R6 banked sp/lr";
    if (i >= 8 && i <= 12)  return "R7 fiq range";
    return "R5 shared reg";
  endfunction

  task automatic check_reads();
    check(reg_tag(rd_a_idx), rd_a_data, m_cur[rd_a_idx]);
    check(reg_tag(rd_b_idx), rd_b_data, m_cur[rd_b_idx]);
  endtask

  task automatic check_state();
    check("R3 status", status, m_status);
    check("R2 mode index", {29'd0, mode_idx}, 32'(code2mode(m_status[4:0])));
    check("R4 error pulse", {31'd0, mode_err}, {31'd0, m_err});
    check("R11 saved status", saved_sr, m_spsr);
  endtask

  task automatic sweep();
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
      #1 check_reads();
    end
  endtask

  // inputs set at negedge; reads compared before the edge, state after it
  task automatic cyc(input bit we, input int idx, input logic [31:0] d,
                     input bit se, input logic [31:0] sd,
                     input bit sre, input logic [31:0] sr);
    wr_en = we; wr_idx = 4'(idx); wr_data = d;
    spsr_wr_en = se; spsr_data = sd;
    sr_wr_en = sre; sr_data = sr;
    #1 check_reads();
    @(posedge clk); model_step();
    @(negedge clk);
    wr_en = 1'b0; spsr_wr_en = 1'b0; sr_wr_en = 1'b0;
    #1 check_state();
  endtask

  task automatic wreg(input int idx, input logic [31:0] d);
    cyc(1, idx, d, 0, '0, 0, '0);
  endtask
  task automatic wsr(input logic [31:0] sr);
    cyc(0, 0, '0, 0, '0, 1, sr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] codes [9];
    codes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h15, 5'h00};
    model_reset();
    repeat (3) @(negedge clk);
    #1 check("R1 reset status", status, 32'h0000_00D3);
    check("R1 reset mode", {29'd0, mode_idx}, 32'd3);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check("R1 status after release", status, 32'h0000_00D3);
    check("R1 error low", {31'd0, mode_err}, 32'd0);
    check("R1 saved zero", saved_sr, 32'd0);
    sweep();

    // fill all registers in supervisor mode
    for (int i = 0; i < 16; i++) wreg(i, 32'hA000_0000 + 32'(i));
    cyc(0, 0, '0, 1, 32'h5A5A_0013, 0, '0);
    sweep();

    // R10: no bypass in the write cycle
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1234_5678; rd_a_idx = 4'd3;
    #1 check("R10 no bypass", rd_a_data, 32'hA000_0003);
    @(posedge clk); model_step();
    @(negedge clk); wr_en = 1'b0;
    #1 check("R10 visible next cycle", rd_a_data, 32'h1234_5678);

    // enter fast interrupt, overwrite its private range
    wsr(32'h0000_00D1);
    rd_a_idx = 4'd8;
    #1 check("R7 fiq copy starts zero", rd_a_data, 32'd0);
    for (int i = 8; i <= 14; i++) wreg(i, 32'hF000_0000 + 32'(i));
    wreg(2, 32'hF0F0_0002);
    sweep();

    // to user: r8-r12 back to supervisor-era values, sp/lr user zeros
    wsr(32'h0000_0010);
    rd_a_idx = 4'd9; rd_b_idx = 4'd13;
    #1 check("R7 shared copy restored", rd_a_data, 32'hA000_0009);
    check("R6 user sp zero", rd_b_data, 32'd0);
    rd_a_idx = 4'd2;
    #1 check("R5 shared across modes", rd_a_data, 32'hF0F0_0002);
    sweep();

    // back to supervisor: banked values restored
    wsr(32'h0000_0013);
    rd_a_idx = 4'd13; rd_b_idx = 4'd14;
    #1 check("R6 svc sp restored", rd_a_data, 32'hA000_000D);
    check("R6 svc lr restored", rd_b_data, 32'hA000_000E);
    check("R6 svc saved restored", saved_sr, 32'h5A5A_0013);

    // invalid code refused
    wsr(32'h0000_0015);
    check("R4 error after bad code", {31'd0, mode_err}, 32'd1);
    check("R4 status held", status, 32'h0000_0013);
    @(negedge clk);
    #1 check("R4 error is one cycle", {31'd0, mode_err}, 32'd0);
    sweep();

    // same-mode write: flags only
    wsr(32'hF000_00D3);
    check("R8 status replaced", status, 32'hF000_00D3);
    check("R8 saved unchanged", saved_sr, 32'h5A5A_0013);
    sweep();

    // writes in the switching cycle go to the old bank
    cyc(1, 13, 32'h0BAD_F00D, 1, 32'h0000_CAFE, 1, 32'h0000_0012);
    rd_a_idx = 4'd13;
    #1 check("R9 irq sp untouched", rd_a_data, 32'd0);
    check("R9 irq saved untouched", saved_sr, 32'd0);
    wsr(32'h0000_0013);
    rd_a_idx = 4'd13;
    #1 check("R9 svc sp took write", rd_a_data, 32'h0BAD_F00D);
    check("R9 svc saved took write", saved_sr, 32'h0000_CAFE);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] sr;
      sr = {$urandom() & 32'hFFFF_FFE0} | {27'd0, codes[$urandom_range(0, 8)]};
      rd_a_idx = 4'($urandom_range(0, 15));
      rd_b_idx = 4'($urandom_range(0, 15));
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom(),
          $urandom_range(0, 3) == 0, $urandom(),
          $urandom_range(0, 4) == 0, sr);
    end
    sweep();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule